// File: doc/BRIEF.md
# Status-Decoded Clock Stop Controller

This block decides when the system clocks of a static design may stop and when they start again. On every rising edge of the main clock it samples a 3-bit processor status bus. When it sees a halt code that comes directly after a passive code, it lets the clocks run for a fixed number of further cycles. It then drops a clock-enable that the clock generator uses to freeze its outputs. In crystal mode it also drops an oscillator-enable. In external-frequency mode it keeps the oscillator running.

A start request, passed through a synchronizer, or an asynchronous reset brings the block back. It enables the oscillator first and raises the clock-enable a fixed number of cycles later, so the first clock after a restart is a full period. A system without a decoded status bus can hold the two low status bits high and use the top bit as a plain active-low stop line.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, osc_en_o is 1 and clk_en_o is 0. After release, clk_en_o rises after WAKE_CYC (default 4) rising edges of clk_i.
- R2: A stop is recognized on a rising edge where stat_i, with bit order {s2,s1,s0}, equals 3'b011, provided the previous rising edge sampled 3'b111. Driving only bit 2 from 1 to 0 while bits 1 and 0 stay high is therefore a valid stop.
- R3: A 3'b011 sample whose previous sample was not 3'b111 has no effect. Any other code that follows a 3'b111 sample also has no effect.
- R4: After the recognizing edge, clk_en_o stays 1 for exactly DRAIN_CYC (default 2) further rising edges and is 0 after the last of them.
- R5: When clk_en_o falls, osc_en_o falls with it if efi_mode_i is 0, and stays 1 if efi_mode_i is 1.
- R6: start_i passes through SYNC_STAGES (default 2) flip-flops. While stopped, the edge that sees the synchronized start sets osc_en_o to 1. clk_en_o then rises WAKE_CYC edges later.
- R7: start_i has no effect while the clocks are enabled.
- R8: After a restart, a new stop needs a fresh 3'b111 sample followed by a 3'b011 sample, all taken while the clocks run. A status held at 3'b011 across the restart does not stop the clocks.
- R9: stat_i is ignored while the clocks are draining, stopped or waking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock, always running |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Processor status {s2,s1,s0} |
| efi_mode_i | input | 1 | 1: external-frequency mode, 0: crystal mode |
| start_i | input | 1 | Asynchronous restart request |
| clk_en_o | output | 1 | System clock enable to the clock generator |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
On every cycle, the bound assertions check the following:
- the clocks never run while the oscillator is off;
- a recognized stop always follows a passive sample;
- the clock-enable stays high for the whole drain window and drops exactly at its end;
- the clock-enable only rises while the oscillator has been on for at least a cycle.

Only the bench scenarios can show the rest:
- codes that must not stop the clocks;
- the difference between the two modes;
- the synchronizer latency and the wake delay;
- the need for a fresh passive sample after a restart.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2,
    ST_WAKE  = 2'd3
  } csc_state_e;

  localparam logic [2:0] STAT_PASSIVE = 3'b111;
  localparam logic [2:0] STAT_HALT    = 3'b011;
endpackage

// File: rtl/csc_start_sync.sv
module csc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/csc_halt_decode.sv
module csc_halt_decode
  import csc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] stat_i,
  output logic       hit_o
);
  // previous sample was passive, taken while running
  logic passive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) passive_q <= 1'b0;
    else         passive_q <= run_i && (stat_i == STAT_PASSIVE);
  end

  assign hit_o = run_i && passive_q && (stat_i == STAT_HALT);
endmodule

// File: rtl/csc_seq.sv
module csc_seq
  import csc_pkg::*;
#(
  parameter int DRAIN_CYC = 2,
  parameter int WAKE_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic start_i,
  input  logic efi_mode_i,
  output logic run_o,
  output logic clk_en_o,
  output logic osc_en_o
);
  localparam int CNT_MAX = (DRAIN_CYC > WAKE_CYC) ? DRAIN_CYC : WAKE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DRAIN_LD = CNT_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);

  csc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             osc_q, osc_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    osc_d   = osc_q;
    unique case (state_q)
      ST_RUN: begin
        if (hit_i) begin
          state_d = ST_DRAIN;
          cnt_d   = DRAIN_LD;
        end
      end
      ST_DRAIN: begin
        if (cnt_q == '0) begin
          state_d = ST_HALT;
          osc_d   = efi_mode_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HALT: begin
        if (start_i) begin
          state_d = ST_WAKE;
          cnt_d   = WAKE_LD;
          osc_d   = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cnt_q == '0) state_d = ST_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAKE;
      cnt_q   <= WAKE_LD;
      osc_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      osc_q   <= osc_d;
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign clk_en_o = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign osc_en_o = osc_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_CYC   = 2,
  parameter int WAKE_CYC    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] stat_i,
  input  logic       efi_mode_i,
  input  logic       start_i,
  output logic       clk_en_o,
  output logic       osc_en_o
);
  logic start_s;
  logic run;
  logic stop_hit;

  csc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (start_i),
    .sync_o  (start_s)
  );

  csc_halt_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .stat_i (stat_i),
    .hit_o  (stop_hit)
  );

  csc_seq #(.DRAIN_CYC(DRAIN_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (stop_hit),
    .start_i    (start_s),
    .efi_mode_i (efi_mode_i),
    .run_o      (run),
    .clk_en_o   (clk_en_o),
    .osc_en_o   (osc_en_o)
  );
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int DRAIN_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] stat_i,
  input logic       stop_hit,
  input logic       clk_en_o,
  input logic       osc_en_o
);
  logic [7:0] drain_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                drain_left_q <= 8'd0;
    else if (stop_hit)          drain_left_q <= 8'(DRAIN_CYC);
    else if (drain_left_q != 0) drain_left_q <= drain_left_q - 8'd1;
  end

  // R5
  clk_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> osc_en_o);

  // R2
  hit_after_passive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit |-> ($past(stat_i) == 3'b111));

  // R4
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_left_q > 8'd1) |=> clk_en_o);

  // R4
  drain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_left_q == 8'd1) |=> !clk_en_o);

  // R6
  wake_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> (osc_en_o && $past(osc_en_o)));
endmodule

bind clk_stop_ctrl csc_checker #(.DRAIN_CYC(DRAIN_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stat_i   (stat_i),
  .stop_hit (stop_hit),
  .clk_en_o (clk_en_o),
  .osc_en_o (osc_en_o)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int SYNC = 2;
  localparam int DRAIN = 2;
  localparam int WAKE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic       efi = 1'b0;
  logic       start = 1'b0;
  logic       clk_en, osc_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_stop_ctrl #(.SYNC_STAGES(SYNC), .DRAIN_CYC(DRAIN), .WAKE_CYC(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stat_i(stat), .efi_mode_i(efi),
    .start_i(start), .clk_en_o(clk_en), .osc_en_o(osc_en)
  );

  // behavioural reference: 0 run, 1 drain, 2 stopped, 3 wake
  int m_mode, m_left;
  bit m_osc, m_pass;
  bit sq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_left = WAKE; m_osc = 1; m_pass = 0;
      sq.delete();
      for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
    end else begin
      bit s_start, was_pass;
      s_start = sq.pop_front();
      sq.push_back(start);
      was_pass = m_pass;
      m_pass = (m_mode == 0) && (stat == 3'b111);
      if (m_mode == 0) begin
        if (was_pass && stat == 3'b011) begin m_mode = 1; m_left = DRAIN; end
      end else if (m_mode == 1) begin
        m_left--;
        if (m_left == 0) begin m_mode = 2; m_osc = efi; end
      end else if (m_mode == 2) begin
        if (s_start) begin m_mode = 3; m_left = WAKE; m_osc = 1; end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      check(clk_en, (m_mode == 0 || m_mode == 1), "R4 model clk_en");
      check(osc_en, m_osc, "R5 model osc_en");
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    tick(2);
    check(clk_en, 1'b0, "R1 clk_en in reset");
    check(osc_en, 1'b1, "R1 osc_en in reset");
    @(negedge clk); rst_n = 1'b1;
    tick(3);
    check(clk_en, 1'b0, "R1 wake gap");
    tick(1);
    check(clk_en, 1'b1, "R1 clocks up");

    // R3: halt code without preceding passive
    stat = 3'b010; tick(1);
    stat = 3'b011; tick(4);
    check(clk_en, 1'b1, "R3 no passive before halt");
    // R3: passive then a different code
    stat = 3'b111; tick(1);
    stat = 3'b001; tick(4);
    check(clk_en, 1'b1, "R3 wrong code after passive");

    // R7: start while running
    start = 1'b1; tick(5);
    check(clk_en, 1'b1, "R7 start ignored");
    start = 1'b0; tick(3);

    // R2/R4/R5: crystal-mode stop via bit 2 falling
    efi = 1'b0;
    stat = 3'b111; tick(1);
    stat = 3'b011; tick(1);
    check(clk_en, 1'b1, "R4 drain cycle 1");
    stat = 3'b111; tick(1);
    check(clk_en, 1'b1, "R4 drain cycle 2");
    stat = 3'b011; tick(1);
    check(clk_en, 1'b0, "R4 stopped");
    check(osc_en, 1'b0, "R5 crystal osc off");
    // R9: status ignored while stopped
    stat = 3'b111; tick(2);
    stat = 3'b011; tick(2);
    check(clk_en, 1'b0, "R9 still stopped");

    // R6: restart, status held at halt code (R8)
    start = 1'b1; tick(2);
    check(osc_en, 1'b0, "R6 sync latency");
    tick(1);
    check(osc_en, 1'b1, "R6 osc back");
    check(clk_en, 1'b0, "R6 clk waits");
    tick(3);
    check(clk_en, 1'b0, "R6 wake gap");
    tick(1);
    check(clk_en, 1'b1, "R6 clocks up");
    start = 1'b0;
    tick(6);
    check(clk_en, 1'b1, "R8 held halt code no stop");

    // R5: external-frequency mode keeps oscillator
    efi = 1'b1;
    stat = 3'b111; tick(1);
    stat = 3'b011; tick(3);
    check(clk_en, 1'b0, "R5 efi clocks stopped");
    check(osc_en, 1'b1, "R5 efi osc kept");
    start = 1'b1; tick(SYNC + 1 + WAKE);
    check(clk_en, 1'b1, "R6 efi restart");
    start = 1'b0;
    stat = 3'b111; tick(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule